// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits in the memory stage of a 32-bit core, between the register file and a byte-addressed data memory that is one word wide. On a load it takes the full memory word and picks out the byte, halfword or word that the access addresses. It moves that field down to bit 0 and then sign-extends or zero-extends it to the register width. On a store it copies the low byte or low halfword of the register value into every matching lane of the write word. It also raises only the byte strobes of the addressed bytes.

Byte numbering inside the word is chosen at run time by a single endianness input, so the same core can run either byte order. A halfword at an odd address, or a word at an address that is not a multiple of four, is not performed. The block flags a load error or a store error instead. All results are registered, so they appear one clock after the request.

Top module: `lsu_align_unit`

## Requirements
- R1: A byte load (size code 2'b00) with the unsigned flag low returns the addressed byte in bits 7:0 with bit 7 copied into every higher bit.
- R2: A byte load with the unsigned flag high returns the addressed byte in bits 7:0 with every higher bit zero.
- R3: A halfword load (size code 2'b01) returns the addressed 16 bits in bits 15:0, sign-extended when the unsigned flag is low and zero-extended when it is high.
- R4: With the endianness input high, address byte 0 is bits 31:24 of the memory word and address byte 3 is bits 7:0, and the first byte of a halfword is its upper byte. With it low, address byte 0 is bits 7:0 and the first byte of a halfword is its lower byte.
- R5: A word load (size code 2'b10, with 2'b11 treated the same) at address offset 0 returns the memory word unchanged, whatever the unsigned flag is.
- R6: A byte store drives the low 8 bits of the register value into all four byte lanes and raises exactly one strobe (strobe bit k enables bits 8k+7:8k), the one for the addressed byte.
- R7: A halfword store drives the low 16 bits of the register value into both halves of the write word and raises the two strobes of the addressed halfword.
- R8: A word store at offset 0 passes the register value unchanged and raises all four strobes.
- R9: A halfword access at an odd offset, or a word access at a nonzero offset, raises the load-error output (for a load) or the store-error output (for a store). In that cycle the load data, write data and strobes are all zero.
- R10: Every output reflects the request of the previous clock edge. A synchronous reset, or a cycle with no valid request, leaves all outputs zero. A load leaves the store outputs zero, and a store leaves the load outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned_i | input | 1 | Zero-extend a load instead of sign-extending it |
| req_addr_lo_i | input | 2 | Byte offset of the access within the word |
| big_endian_i | input | 1 | 1 = byte 0 is the most significant byte |
| mem_rdata_i | input | 32 | Word read from memory for a load |
| reg_wdata_i | input | 32 | Register value to store |
| ld_data_o | output | 32 | Aligned and extended load result |
| ld_err_o | output | 1 | Misaligned load flagged |
| st_data_o | output | 32 | Write word with the data replicated across lanes |
| st_strb_o | output | 4 | Byte write strobes |
| st_err_o | output | 1 | Misaligned store flagged |

## Verification
Load data uses two memory words. In the first, the bytes alternate between a set and a clear top bit. In the second, one halfword is negative and the other positive. Every offset is run in both byte orders and with both extension flags, so a wrong lane choice, a swapped byte order or a wrong extension each gives a different value. Store data carries distinct values in its low byte, its low halfword and its upper bits, which shows that only the low field is copied and that the strobes follow the endianness. Every odd halfword offset and every nonzero word offset is tried as both a load and a store. Idle cycles and load/store alternation show that the unused path stays zero.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;

  // Access size codes on req_size_i; 2'b11 behaves as a word.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

endpackage

// File: rtl/lsu_lane_map.sv
`timescale 1ns/1ps
// Maps an address offset, size and byte order onto physical byte lanes.
module lsu_lane_map
  import lsu_align_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = $clog2(NB)
) (
  input  acc_size_e         size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              big_endian_i,
  output logic              misalign_o,
  output logic [AW-1:0]     low_lane_o,
  output logic [NB-1:0]     lane_mask_o
);

  localparam logic [AW-1:0] TOP_LANE  = AW'(NB - 1);
  localparam logic [AW-1:0] HALF_TOP  = AW'(NB - 2);
  localparam logic [NB-1:0] ONE_LANE  = NB'(1);
  localparam logic [NB-1:0] TWO_LANES = NB'(3);

  always_comb begin
    misalign_o  = 1'b0;
    low_lane_o  = '0;
    lane_mask_o = '1;
    unique case (size_i)
      SZ_BYTE: begin
        low_lane_o  = big_endian_i ? (TOP_LANE - addr_i) : addr_i;
        lane_mask_o = ONE_LANE << low_lane_o;
      end
      SZ_HALF: begin
        misalign_o  = addr_i[0];
        low_lane_o  = big_endian_i ? (HALF_TOP - addr_i) : addr_i;
        lane_mask_o = TWO_LANES << low_lane_o;
      end
      default: begin
        misalign_o  = (addr_i != '0);
        low_lane_o  = '0;
        lane_mask_o = '1;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
// Shifts the selected field to bit 0 and extends it to full width.
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW / 8)
) (
  input  logic [DW-1:0] rdata_i,
  input  acc_size_e     size_i,
  input  logic          unsigned_i,
  input  logic [AW-1:0] low_lane_i,
  output logic [DW-1:0] value_o
);

  localparam int SHW = AW + 3;

  logic [SHW-1:0] bit_shift;
  logic [DW-1:0]  shifted;
  logic           fill_b;
  logic           fill_h;

  assign bit_shift = {low_lane_i, 3'b000};
  assign shifted   = rdata_i >> bit_shift;
  assign fill_b    = ~unsigned_i & shifted[7];
  assign fill_h    = ~unsigned_i & shifted[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(DW-8){fill_b}}, shifted[7:0]};
      SZ_HALF: value_o = {{(DW-16){fill_h}}, shifted[15:0]};
      default: value_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_store_replicate.sv
`timescale 1ns/1ps
// Copies the low byte or halfword of the store value into every lane.
module lsu_store_replicate
  import lsu_align_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] wdata_i,
  input  acc_size_e     size_i,
  output logic [DW-1:0] word_o
);

  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic [DW-1:0] byte_rep;
  logic [DW-1:0] half_rep;

  for (genvar g = 0; g < NB; g++) begin : g_byte_lane
    assign byte_rep[8*g +: 8] = wdata_i[7:0];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half_lane
    assign half_rep[16*h +: 16] = wdata_i[15:0];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: word_o = byte_rep;
      SZ_HALF: word_o = half_rep;
      default: word_o = wdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_align_unit.sv
`timescale 1ns/1ps
// Load/store byte lane aligner with registered outputs.
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  input  logic          req_store_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_unsigned_i,
  input  logic [AW-1:0] req_addr_lo_i,
  input  logic          big_endian_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] ld_data_o,
  output logic          ld_err_o,
  output logic [DW-1:0] st_data_o,
  output logic [NB-1:0] st_strb_o,
  output logic          st_err_o
);

  acc_size_e     size;
  logic          misalign;
  logic [AW-1:0] low_lane;
  logic [NB-1:0] lane_mask;
  logic [DW-1:0] ld_value;
  logic [DW-1:0] st_word;
  logic          do_load;
  logic          do_store;

  assign size     = acc_size_e'(req_size_i);
  assign do_load  = req_valid_i & ~req_store_i;
  assign do_store = req_valid_i &  req_store_i;

  lsu_lane_map #(.NB(NB), .AW(AW)) u_map (
    .size_i       (size),
    .addr_i       (req_addr_lo_i),
    .big_endian_i (big_endian_i),
    .misalign_o   (misalign),
    .low_lane_o   (low_lane),
    .lane_mask_o  (lane_mask)
  );

  lsu_load_extract #(.DW(DW), .AW(AW)) u_ld (
    .rdata_i    (mem_rdata_i),
    .size_i     (size),
    .unsigned_i (req_unsigned_i),
    .low_lane_i (low_lane),
    .value_o    (ld_value)
  );

  lsu_store_replicate #(.DW(DW)) u_st (
    .wdata_i (reg_wdata_i),
    .size_i  (size),
    .word_o  (st_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_data_o <= '0;
      ld_err_o  <= 1'b0;
      st_data_o <= '0;
      st_strb_o <= '0;
      st_err_o  <= 1'b0;
    end else begin
      ld_err_o  <= do_load & misalign;
      st_err_o  <= do_store & misalign;
      ld_data_o <= (do_load  & ~misalign) ? ld_value  : '0;
      st_data_o <= (do_store & ~misalign) ? st_word   : '0;
      st_strb_o <= (do_store & ~misalign) ? lane_mask : '0;
    end
  end

endmodule

// File: rtl/lsu_align_checker.sv
`timescale 1ns/1ps
module lsu_align_checker #(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int AW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid_i,
  input logic          req_store_i,
  input logic [1:0]    req_size_i,
  input logic          req_unsigned_i,
  input logic [AW-1:0] req_addr_lo_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic [DW-1:0] ld_data_o,
  input logic          ld_err_o,
  input logic [DW-1:0] st_data_o,
  input logic [NB-1:0] st_strb_o,
  input logic          st_err_o
);

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ld_data_o == '0 && st_data_o == '0 && st_strb_o == '0
                    && !ld_err_o && !st_err_o));

  p_err_no_strb_r9: assert property (@(posedge clk) disable iff (rst)
    st_err_o |-> (st_strb_o == '0 && st_data_o == '0));

  p_err_no_data_r9: assert property (@(posedge clk) disable iff (rst)
    ld_err_o |-> (ld_data_o == '0));

  p_half_odd_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && req_size_i == 2'b01 && req_addr_lo_i[0])
      |-> (ld_err_o || st_err_o));

  p_byte_one_strb_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && req_store_i && req_size_i == 2'b00)
      |-> ($countones(st_strb_o) == 1));

  p_word_pass_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && !req_store_i && req_size_i[1] && req_addr_lo_i == '0)
      |-> (ld_data_o == $past(mem_rdata_i)));

  p_byte_sext_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && !req_store_i && req_size_i == 2'b00 && !req_unsigned_i)
      |-> (ld_data_o[DW-1:8] == {(DW-8){ld_data_o[7]}}));

endmodule

bind lsu_align_unit lsu_align_checker #(.DW(DW), .NB(NB), .AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid_i    (req_valid_i),
  .req_store_i    (req_store_i),
  .req_size_i     (req_size_i),
  .req_unsigned_i (req_unsigned_i),
  .req_addr_lo_i  (req_addr_lo_i),
  .mem_rdata_i    (mem_rdata_i),
  .ld_data_o      (ld_data_o),
  .ld_err_o       (ld_err_o),
  .st_data_o      (st_data_o),
  .st_strb_o      (st_strb_o),
  .st_err_o       (st_err_o)
);

// File: tb/lsu_align_unit_bench.sv
`timescale 1ns/1ps
module lsu_align_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [1:0]  req_size_i = 2'b00;
  logic        req_unsigned_i = 1'b0;
  logic [1:0]  req_addr_lo_i = 2'b00;
  logic        big_endian_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] ld_data_o;
  logic        ld_err_o;
  logic [31:0] st_data_o;
  logic [3:0]  st_strb_o;
  logic        st_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lsu_align_unit u_lsu_align_unit (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_store_i(req_store_i),
    .req_size_i(req_size_i), .req_unsigned_i(req_unsigned_i),
    .req_addr_lo_i(req_addr_lo_i), .big_endian_i(big_endian_i),
    .mem_rdata_i(mem_rdata_i), .reg_wdata_i(reg_wdata_i),
    .ld_data_o(ld_data_o), .ld_err_o(ld_err_o), .st_data_o(st_data_o),
    .st_strb_o(st_strb_o), .st_err_o(st_err_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one request, then wait past the capturing edge.
  task automatic issue(input bit st, input logic [1:0] sz, input bit uns,
                       input logic [1:0] a, input bit bend,
                       input logic [31:0] rd, input logic [31:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1; req_store_i = st; req_size_i = sz;
    req_unsigned_i = uns; req_addr_lo_i = a; big_endian_i = bend;
    mem_rdata_i = rd; reg_wdata_i = wd;
    @(posedge clk);
    #1;
  endtask

  // Reference: memory byte at address offset a.
  function automatic logic [7:0] mbyte(input logic [31:0] w, input int a, input bit bend);
    return bend ? w[8*(3-a) +: 8] : w[8*a +: 8];
  endfunction

  function automatic int lane_of(input int a, input bit bend);
    return bend ? 3 - a : a;
  endfunction

  task automatic t_reset();
    chk("R10", "reset ld_data", ld_data_o, 32'h0);
    chk("R10", "reset strb", {28'h0, st_strb_o}, 32'h0);
    chk("R10", "reset errs", {30'h0, ld_err_o, st_err_o}, 32'h0);
  endtask

  task automatic t_byte_loads(input logic [31:0] w);
    for (int be = 0; be < 2; be++)
      for (int a = 0; a < 4; a++) begin
        logic [7:0] b;
        b = mbyte(w, a, be[0]);
        issue(1'b0, 2'b00, 1'b0, a[1:0], be[0], w, 32'h0);
        chk("R1 R4", $sformatf("lb be=%0d a=%0d", be, a), ld_data_o, {{24{b[7]}}, b});
        issue(1'b0, 2'b00, 1'b1, a[1:0], be[0], w, 32'h0);
        chk("R2 R4", $sformatf("lbu be=%0d a=%0d", be, a), ld_data_o, {24'h0, b});
      end
  endtask

  task automatic t_half_loads(input logic [31:0] w);
    for (int be = 0; be < 2; be++)
      for (int a = 0; a < 4; a += 2) begin
        logic [15:0] h;
        h = be ? {mbyte(w, a, 1'b1), mbyte(w, a + 1, 1'b1)}
               : {mbyte(w, a + 1, 1'b0), mbyte(w, a, 1'b0)};
        issue(1'b0, 2'b01, 1'b0, a[1:0], be[0], w, 32'h0);
        chk("R3 R4", $sformatf("lh be=%0d a=%0d", be, a), ld_data_o, {{16{h[15]}}, h});
        issue(1'b0, 2'b01, 1'b1, a[1:0], be[0], w, 32'h0);
        chk("R3 R4", $sformatf("lhu be=%0d a=%0d", be, a), ld_data_o, {16'h0, h});
      end
  endtask

  task automatic t_word_loads();
    for (int sz = 2; sz < 4; sz++)
      for (int u = 0; u < 2; u++) begin
        issue(1'b0, sz[1:0], u[0], 2'b00, u[0], 32'h9C3E_5A17, 32'h0);
        chk("R5", $sformatf("lw sz=%0d uns=%0d", sz, u), ld_data_o, 32'h9C3E_5A17);
        chk("R10", "lw store side idle", {st_strb_o, st_data_o[27:0]}, 32'h0);
      end
  endtask

  task automatic t_byte_stores();
    for (int be = 0; be < 2; be++)
      for (int a = 0; a < 4; a++) begin
        issue(1'b1, 2'b00, 1'b0, a[1:0], be[0], 32'hFFFF_FFFF, 32'h1234_56C9);
        chk("R6", $sformatf("sb data be=%0d a=%0d", be, a), st_data_o, 32'hC9C9_C9C9);
        chk("R6 R4", $sformatf("sb strb be=%0d a=%0d", be, a),
            {28'h0, st_strb_o}, 32'(1 << lane_of(a, be[0])));
        chk("R10", "sb load side idle", ld_data_o, 32'h0);
      end
  endtask

  task automatic t_half_stores();
    for (int be = 0; be < 2; be++)
      for (int a = 0; a < 4; a += 2) begin
        int l0, l1;
        l0 = lane_of(a, be[0]); l1 = lane_of(a + 1, be[0]);
        issue(1'b1, 2'b01, 1'b0, a[1:0], be[0], 32'h0, 32'hABCD_8E71);
        chk("R7", $sformatf("sh data be=%0d a=%0d", be, a), st_data_o, 32'h8E71_8E71);
        chk("R7 R4", $sformatf("sh strb be=%0d a=%0d", be, a),
            {28'h0, st_strb_o}, 32'((1 << l0) | (1 << l1)));
      end
  endtask

  task automatic t_word_store();
    for (int be = 0; be < 2; be++) begin
      issue(1'b1, 2'b10, 1'b0, 2'b00, be[0], 32'h0, 32'h0F1E_2D3C);
      chk("R8", "sw data", st_data_o, 32'h0F1E_2D3C);
      chk("R8", "sw strb", {28'h0, st_strb_o}, 32'hF);
      chk("R9", "sw no error", {31'h0, st_err_o}, 32'h0);
    end
  endtask

  task automatic t_misaligned();
    for (int st = 0; st < 2; st++) begin
      for (int a = 1; a < 4; a += 2) begin
        issue(st[0], 2'b01, 1'b0, a[1:0], 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R9", $sformatf("half odd st=%0d a=%0d errs", st, a),
            {30'h0, ld_err_o, st_err_o}, st ? 32'h1 : 32'h2);
        chk("R9", "half odd outputs zero", ld_data_o | st_data_o | {28'h0, st_strb_o}, 32'h0);
      end
      for (int a = 1; a < 4; a++) begin
        issue(st[0], 2'b10, 1'b0, a[1:0], 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R9", $sformatf("word off st=%0d a=%0d errs", st, a),
            {30'h0, ld_err_o, st_err_o}, st ? 32'h1 : 32'h2);
        chk("R9", "word off outputs zero", ld_data_o | st_data_o | {28'h0, st_strb_o}, 32'h0);
      end
    end
  endtask

  task automatic t_idle();
    issue(1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    @(negedge clk);
    req_valid_i = 1'b0;
    @(posedge clk);
    #1;
    chk("R10", "idle outputs", ld_data_o | st_data_o | {28'h0, st_strb_o}, 32'h0);
    chk("R10", "idle errs", {30'h0, ld_err_o, st_err_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_byte_loads(32'h8142_F364);
    t_half_loads(32'h8142_F364);
    t_half_loads(32'h7F01_80FE);
    t_word_loads();
    t_byte_stores();
    t_half_stores();
    t_word_store();
    t_misaligned();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule